// File: doc/BRIEF.md
# Sixteen-Channel Table-Driven Trigger Unit

This block decides, sample by sample, whether a 16-bit logic stream has met a programmed trigger condition. The channels are split into four groups of four. Each group's 4-bit slice indexes small 16-entry truth tables. One set of tables forms a value/mask match. Two further sets each form a single-channel edge detector. A 16-entry glue table looks at the previous and current outputs of both detectors and decides whether the wanted edge occurred. A fixed final table then combines the glue result, the value/mask result, an auxiliary table bit and a "previous sample exists" flag.

Software loads the tables one column at a time. It first writes a 14-bit data word that holds bit *i* of every table. It then issues a select write that commits that column. When the condition holds, the unit emits a one-cycle trigger pulse. It keeps a sticky triggered flag until it is re-armed.

Top module: `trg_unit`

## Requirements
- R1: The value/mask term is the AND of four group lookups. Group g (channels 4g..4g+3) indexes its own 16-bit table with nibble `smp_i[4g+3:4g]`. A table holds a 0 at every index where a masked channel disagrees with its required value.
- R2: Each of the two edge detectors (A and B) outputs the AND of its own four group lookups on the current sample. A detector that watches channel c has a group table that is 1 only where bit c is set, and all-ones tables elsewhere.
- R3: The glue table is indexed by {B previous, B current, A previous, A current}, with bit 0 being A current. A rising edge on A selects the entries whose bits [1:0] are 01. A falling edge on A selects the entries whose bits [1:0] are 10. The same rule applies to B on bits [3:2], and the selections of A and B are ORed. An all-ones glue table leaves the decision to the value/mask term alone.
- R4: A trigger fires when the final table (default 16'hA000) is 1 at index {glue, value/mask, aux, previous-sample-valid}. The auxiliary lookup is indexed by channels 3:0. With the default final table, the auxiliary lookup has no effect.
- R5: The layout of a `cfg_data_i` word is as follows. Bits [3:0] are the value/mask bits of groups 0..3. Bit 4 is the glue bit and bit 5 is the aux bit. Bits [9:6] are the detector A bits of groups 0..3. Bits [13:10] are the detector B bits. The word is held until the next data write.
- R6: A select write whose upper nibble is 4'h3 commits the held word into table column `cfg_sel_i[3:0]` of every table. A select write with any other upper nibble leaves all tables unchanged.
- R7: The trigger pulse `trig_o` is high for exactly one cycle. It appears on the clock edge after the qualifying sample is presented with `smp_valid_i`.
- R8: The first valid sample after reset or after `arm_i` never fires. Previous detector values come only from samples presented with `smp_valid_i`.
- R9: `triggered_o` rises together with the pulse. It stays high, and further pulses are blocked, until `arm_i` clears it. A sample presented in the same cycle as `arm_i` is dropped.
- R10: After reset, all tables are zero and both outputs are low. No sample can fire until the tables are loaded.
- R11: Cycles in which `smp_valid_i` is low neither fire nor change the remembered previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Re-arm: clears the flag and the previous-sample history |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | 16 | Sample of the sixteen channels |
| cfg_data_we_i | input | 1 | Write strobe for the column data word |
| cfg_data_i | input | 14 | Column data word (layout in R5) |
| cfg_sel_we_i | input | 1 | Write strobe for the select/commit byte |
| cfg_sel_i | input | 8 | Commit tag (upper nibble) and column index (lower nibble) |
| trig_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Sticky triggered flag |

## Verification
A corrupted table column shows up at the ports only when a sample lands on that column's index: the trigger then fires at the wrong sample, or never fires. The bench therefore aims samples at the specific nibble values it has just rewritten. A lost or stale previous-detector bit shows one cycle later, as an edge trigger that fires on a level or misses a real edge. The bench covers this with runs that hold a level, runs that change it, and runs with idle gaps between samples. A wrong sticky or history state shows on the very next sample after re-arming, as a premature pulse or a missing one.

// File: rtl/trg_pkg.sv
package trg_pkg;
    parameter int unsigned GRP_W    = 4;
    parameter int unsigned NUM_GRP  = 4;
    parameter int unsigned SEL_W    = 8;
    localparam int unsigned CH_W    = GRP_W * NUM_GRP;
    localparam int unsigned TAB_D   = 1 << GRP_W;
    localparam int unsigned CFG_W   = 3 * NUM_GRP + 2;
    localparam int unsigned TAG_W   = SEL_W - GRP_W;
    localparam int unsigned GLUE_POS = NUM_GRP;
    localparam int unsigned AUX_POS  = NUM_GRP + 1;
    localparam int unsigned EA_BASE  = NUM_GRP + 2;
    localparam int unsigned EB_BASE  = 2 * NUM_GRP + 2;
endpackage

// File: rtl/trg_cfg_store.sv
module trg_cfg_store
    import trg_pkg::*;
#(
    parameter logic [TAG_W-1:0] COMMIT_TAG = 4'h3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             data_we_i,
    input  logic [CFG_W-1:0]                 data_i,
    input  logic                             sel_we_i,
    input  logic [SEL_W-1:0]                 sel_i,
    output logic [NUM_GRP-1:0][TAB_D-1:0]    vm_tab_o,
    output logic [NUM_GRP-1:0][TAB_D-1:0]    ea_tab_o,
    output logic [NUM_GRP-1:0][TAB_D-1:0]    eb_tab_o,
    output logic [TAB_D-1:0]                 glue_tab_o,
    output logic [TAB_D-1:0]                 aux_tab_o
);
    typedef struct packed {
        logic [CFG_W-1:0]              hold;
        logic [NUM_GRP-1:0][TAB_D-1:0] vm;
        logic [NUM_GRP-1:0][TAB_D-1:0] ea;
        logic [NUM_GRP-1:0][TAB_D-1:0] eb;
        logic [TAB_D-1:0]              glue;
        logic [TAB_D-1:0]              aux;
    } cfg_st_t;

    cfg_st_t           st_d, st_q;
    logic              commit;
    logic [GRP_W-1:0]  step;

    assign commit = sel_we_i && (sel_i[SEL_W-1:GRP_W] == COMMIT_TAG);
    assign step   = sel_i[GRP_W-1:0];

    always_comb begin
        st_d = st_q;
        if (data_we_i) begin
            st_d.hold = data_i;
        end
        if (commit) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                st_d.vm[g][step] = st_q.hold[g];
                st_d.ea[g][step] = st_q.hold[EA_BASE + g];
                st_d.eb[g][step] = st_q.hold[EB_BASE + g];
            end
            st_d.glue[step] = st_q.hold[GLUE_POS];
            st_d.aux[step]  = st_q.hold[AUX_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vm_tab_o   = st_q.vm;
    assign ea_tab_o   = st_q.ea;
    assign eb_tab_o   = st_q.eb;
    assign glue_tab_o = st_q.glue;
    assign aux_tab_o  = st_q.aux;

    p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_we_i |=> st_q.hold == $past(data_i));

    p_commit_column_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (glue_tab_o[$past(step)] == $past(st_q.hold[GLUE_POS]))
                && (vm_tab_o[0][$past(step)] == $past(st_q.hold[0])));

    p_foreign_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(vm_tab_o) && $stable(ea_tab_o) && $stable(eb_tab_o)
                 && $stable(glue_tab_o) && $stable(aux_tab_o));
endmodule

// File: rtl/trg_grp_match.sv
module trg_grp_match
    import trg_pkg::*;
(
    input  logic [NUM_GRP-1:0][TAB_D-1:0] tab_i,
    input  logic [CH_W-1:0]               smp_i,
    output logic                          hit_o
);
    logic [NUM_GRP-1:0] grp_hit;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_hit[g] = tab_i[g][smp_i[g*GRP_W +: GRP_W]];
    end

    assign hit_o = &grp_hit;
endmodule

// File: rtl/trg_core.sv
module trg_core
    import trg_pkg::*;
#(
    parameter logic [15:0] FINAL_LUT = 16'hA000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              smp_valid_i,
    input  logic              vm_hit_i,
    input  logic              ea_hit_i,
    input  logic              eb_hit_i,
    input  logic              aux_hit_i,
    input  logic [TAB_D-1:0]  glue_tab_i,
    output logic              trig_o,
    output logic              triggered_o
);
    typedef struct packed {
        logic prev_valid;
        logic ea_prev;
        logic eb_prev;
        logic trig;
        logic fired;
    } core_st_t;

    core_st_t    st_d, st_q;
    logic [3:0]  glue_idx;
    logic        glue_hit;
    logic [3:0]  final_idx;
    logic        fire;

    assign glue_idx  = {st_q.eb_prev, eb_hit_i, st_q.ea_prev, ea_hit_i};
    assign glue_hit  = glue_tab_i[glue_idx];
    assign final_idx = {glue_hit, vm_hit_i, aux_hit_i, st_q.prev_valid};
    assign fire      = FINAL_LUT[final_idx] && !st_q.fired;

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        if (arm_i) begin
            st_d.prev_valid = 1'b0;
            st_d.fired      = 1'b0;
        end else if (smp_valid_i) begin
            st_d.trig       = fire;
            st_d.fired      = st_q.fired || fire;
            st_d.ea_prev    = ea_hit_i;
            st_d.eb_prev    = eb_hit_i;
            st_d.prev_valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o      = st_q.trig;
    assign triggered_o = st_q.fired;

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    p_flag_with_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> triggered_o);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered_o && !arm_i) |=> triggered_o);

    p_arm_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (!triggered_o && !trig_o));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> !trig_o);

    p_first_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && !st_q.prev_valid) |=> !trig_o);

    p_glue_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && !glue_hit) |=> !trig_o);
endmodule

// File: rtl/trg_unit.sv
module trg_unit
    import trg_pkg::*;
#(
    parameter logic [15:0]      FINAL_LUT  = 16'hA000,
    parameter logic [TAG_W-1:0] COMMIT_TAG = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              smp_valid_i,
    input  logic [CH_W-1:0]   smp_i,
    input  logic              cfg_data_we_i,
    input  logic [CFG_W-1:0]  cfg_data_i,
    input  logic              cfg_sel_we_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    output logic              trig_o,
    output logic              triggered_o
);
    logic [NUM_GRP-1:0][TAB_D-1:0] vm_tab, ea_tab, eb_tab;
    logic [TAB_D-1:0]              glue_tab, aux_tab;
    logic                          vm_hit, ea_hit, eb_hit, aux_hit;

    trg_cfg_store #(.COMMIT_TAG(COMMIT_TAG)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_we_i (cfg_data_we_i),
        .data_i    (cfg_data_i),
        .sel_we_i  (cfg_sel_we_i),
        .sel_i     (cfg_sel_i),
        .vm_tab_o  (vm_tab),
        .ea_tab_o  (ea_tab),
        .eb_tab_o  (eb_tab),
        .glue_tab_o(glue_tab),
        .aux_tab_o (aux_tab)
    );

    trg_grp_match u_vm (.tab_i(vm_tab), .smp_i(smp_i), .hit_o(vm_hit));
    trg_grp_match u_ea (.tab_i(ea_tab), .smp_i(smp_i), .hit_o(ea_hit));
    trg_grp_match u_eb (.tab_i(eb_tab), .smp_i(smp_i), .hit_o(eb_hit));

    assign aux_hit = aux_tab[smp_i[GRP_W-1:0]];

    trg_core #(.FINAL_LUT(FINAL_LUT)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm_i),
        .smp_valid_i (smp_valid_i),
        .vm_hit_i    (vm_hit),
        .ea_hit_i    (ea_hit),
        .eb_hit_i    (eb_hit),
        .aux_hit_i   (aux_hit),
        .glue_tab_i  (glue_tab),
        .trig_o      (trig_o),
        .triggered_o (triggered_o)
    );
endmodule

// File: tb/trg_unit_test.sv
`timescale 1ns/1ps
module trg_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [15:0] smp_i = '0;
    logic        cfg_data_we_i = 1'b0;
    logic [13:0] cfg_data_i = '0;
    logic        cfg_sel_we_i = 1'b0;
    logic [7:0]  cfg_sel_i = '0;
    logic        trig_o, triggered_o;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    trg_unit uut (.*);

    // {arm before, sample, expected pulse}; value 0x5 on ch3:0, rising ch8
    localparam logic [17:0] VEC [0:9] = '{
        {1'b1, 16'h0005, 1'b0},
        {1'b0, 16'h0104, 1'b0},
        {1'b0, 16'h0005, 1'b0},
        {1'b0, 16'h0105, 1'b1},
        {1'b0, 16'h0005, 1'b0},
        {1'b0, 16'h0105, 1'b0},
        {1'b1, 16'h0105, 1'b0},
        {1'b0, 16'h0105, 1'b0},
        {1'b0, 16'h0005, 1'b0},
        {1'b0, 16'hF105, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit tab_bit(input logic [15:0] val, input logic [15:0] msk,
                                   input int g, input int j);
        bit ok = 1'b1;
        for (int k = 0; k < 4; k++) begin
            if (msk[g*4+k] && (val[g*4+k] != j[k])) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic bit edge_bit(input int ch, input int mode, input int g, input int j);
        logic [15:0] b;
        if (mode == 0) return 1'b1;
        b = 16'h1 << ch;
        return tab_bit(b, b, g, j);
    endfunction

    function automatic bit glue_bit(input int am, input int bm, input int j);
        logic [3:0] x;
        x = j[3:0];
        if (am == 0 && bm == 0) return 1'b1;
        return (am == 1 && x[1:0] == 2'b01) || (am == 2 && x[1:0] == 2'b10)
            || (bm == 1 && x[3:2] == 2'b01) || (bm == 2 && x[3:2] == 2'b10);
    endfunction

    task automatic cfg_word(input logic [13:0] w);
        cfg_data_we_i = 1'b1; cfg_data_i = w;
        @(negedge clk);
        cfg_data_we_i = 1'b0;
    endtask

    task automatic cfg_sel(input logic [7:0] s);
        cfg_sel_we_i = 1'b1; cfg_sel_i = s;
        @(negedge clk);
        cfg_sel_we_i = 1'b0;
    endtask

    // R5 layout: [3:0] vm, [4] glue, [5] aux, [9:6] det A, [13:10] det B
    task automatic load(input logic [15:0] val, input logic [15:0] msk,
                        input int ach, input int am, input int bch, input int bm,
                        input bit aux1);
        for (int j = 0; j < 16; j++) begin
            logic [13:0] w;
            for (int g = 0; g < 4; g++) begin
                w[g]      = tab_bit(val, msk, g, j);
                w[6 + g]  = edge_bit(ach, am, g, j);
                w[10 + g] = edge_bit(bch, bm, g, j);
            end
            w[4] = glue_bit(am, bm, j);
            w[5] = aux1;
            cfg_word(w);
            cfg_sel(8'h30 | 8'(j));
        end
    endtask

    task automatic do_arm();
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
    endtask

    task automatic push(input logic [15:0] s, input logic exp, input string req);
        smp_i = s; smp_valid_i = 1'b1;
        @(negedge clk);
        smp_valid_i = 1'b0;
        check(req, trig_o, exp);
    endtask

    task automatic idle(input logic [15:0] s);
        smp_i = s; smp_valid_i = 1'b0;
        @(negedge clk);
        check("R11 idle cycle", trig_o, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state, empty tables never fire
        check("R10 trig after reset", trig_o, 1'b0);
        check("R10 flag after reset", triggered_o, 1'b0);
        do_arm();
        push(16'h0000, 1'b0, "R10 empty tables");
        push(16'h0000, 1'b0, "R10 empty tables");

        // R1 R3 R7 R8 R9: vector walk, value 0x5 on ch3:0, rising ch8 in A
        load(16'h0005, 16'h000F, 8, 1, 0, 0, 1'b1);
        for (int v = 0; v < 10; v++) begin
            if (VEC[v][17]) do_arm();
            push(VEC[v][16:1], VEC[v][0], $sformatf("R1/R3/R8/R9 vector %0d", v));
        end

        // R11: invalid cycles do not move the previous sample
        do_arm();
        push(16'h0005, 1'b0, "R8 first after arm");
        idle(16'h0105);
        idle(16'h0105);
        push(16'h0105, 1'b1, "R11 edge across idle gap");
        check("R9 flag set", triggered_o, 1'b1);
        idle(16'h0005);
        check("R9 flag sticky", triggered_o, 1'b1);
        do_arm();
        check("R9 arm clears flag", triggered_o, 1'b0);

        // R2 R3 R4: rising ch2 in A, falling ch13 in B, no value term, aux zero
        load(16'h0000, 16'h0000, 2, 1, 13, 2, 1'b0);
        do_arm();
        push(16'h2000, 1'b0, "R8 first after arm");
        push(16'h2000, 1'b0, "R2 level held on B");
        push(16'h0000, 1'b1, "R2/R3 falling on B, aux zero R4");
        do_arm();
        push(16'h0000, 1'b0, "R8 first after arm");
        push(16'h0004, 1'b1, "R2/R3 rising on A ORed");
        do_arm();
        push(16'h0004, 1'b0, "R8 first after arm");
        push(16'h0000, 1'b0, "R3 falling on A not selected");

        // R3 R4 R6: value-only, glue all ones
        load(16'hABCD, 16'hFFFF, 0, 0, 0, 0, 1'b1);
        do_arm();
        push(16'hABCD, 1'b0, "R8 first after arm");
        push(16'hABCC, 1'b0, "R1 mismatch group 0");
        push(16'hABCD, 1'b1, "R1/R3 value match, glue all ones");
        cfg_word(14'h0000);
        cfg_sel(8'h2D);
        cfg_sel(8'h4D);
        do_arm();
        push(16'hABCD, 1'b0, "R8 first after arm");
        push(16'hABCD, 1'b1, "R6 foreign select ignored");
        cfg_sel(8'h3D);
        do_arm();
        push(16'hABCD, 1'b0, "R8 first after arm");
        push(16'hABCD, 1'b0, "R6 column 13 cleared");
        push(16'hABCE, 1'b0, "R1 other mismatch");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule